// File: doc/BRIEF.md
# Dual round-robin matching scheduler

This block computes one crossbar matching per cell slot for an N x N input-queued switch that keeps a virtual output queue for every input/output pair. The caller presents an occupancy matrix and pulses a slot strobe. The scheduler then works in two stages:

- **Request stage.** Every input with at least one non-empty queue names exactly one output. It picks that output with its own rotating pointer.
- **Grant stage.** Every output that was named picks one of its requesters with its own rotating pointer.

The grants that result are the matching. There is no accept phase, because no input can receive more than one grant. This keeps the arbitration at two short cycles.

The control is a two-state machine:

- **IDLE** waits for the strobe. The transition *launch* (IDLE to RESOLVE, taken when the strobe is high) registers the requests.
- **RESOLVE** computes the grants. The transition *publish* (RESOLVE to IDLE, always taken) registers the grant matrix, raises the valid flag for one cycle and moves the pointers.

Matrix encoding for both `occ_i` and `grant_o`: bit `i*N + j` refers to input `i` and output `j`.

Top module: `drrm_sched`

## Requirements
- R1: After reset `match_valid_o` is 0, `grant_o` is all zeros, and every input and output pointer is 0.
- R2: A strobe accepted in IDLE at clock edge k makes `match_valid_o` high for exactly one cycle, after edge k+1, and low again after edge k+2.
- R3: Each input requests only the first occupied output found by scanning cyclically upward from its pointer. An input with no occupied output requests nothing.
- R4: Each output grants the first requesting input found by scanning cyclically upward from its own pointer.
- R5: Every grant row and every grant column has at most one bit set, and a grant bit is set only where the sampled occupancy bit was 1.
- R6: A granted input moves its pointer to one past its requested output, modulo N. An input that is not granted keeps its pointer.
- R7: An output that grants moves its pointer to one past the granted input, modulo N. An output with no request keeps its pointer.
- R8: A strobe that arrives while in RESOLVE is ignored. It produces no second result and moves no pointer.
- R9: Occupancy is sampled only on the launch edge. A change after that edge does not alter the published matching.
- R10: `grant_o` holds its value between results. An all-empty occupancy still produces a valid pulse, with an all-zero grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_i | input | 1 | Slot strobe; starts one matching when in IDLE |
| occ_i | input | N*N | Queue occupancy, bit i*N+j = input i holds a cell for output j |
| grant_o | output | N*N | Matching, bit i*N+j = input i connected to output j |
| match_valid_o | output | 1 | One-cycle pulse marking a new matching on grant_o |

## Verification
Every pointer state shows up in the choice of partners on a later slot. A stale or wrongly advanced pointer therefore produces a matching that differs from the reference on the next slot, or at the latest within N slots of full occupancy. A wrong state-machine state shows at once, as a missing, doubled or early valid pulse, or as a grant matrix that changes without one. A leak in the request register shows on the first slot whose occupancy changes after launch.

// File: rtl/drrm_pkg.sv
package drrm_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESOLVE = 1'b1
    } drrm_state_e;
endpackage

// File: rtl/drrm_rr_pick.sv
module drrm_rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          hit,
    output logic [PW-1:0] idx
);
    // First set bit at or cyclically after ptr
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            automatic int p = int'(ptr) + k;
            if (p >= N) p = p - N;
            if (!hit && req[p]) begin
                hit = 1'b1;
                idx = PW'(p);
            end
        end
    end
endmodule

// File: rtl/drrm_req_stage.sv
module drrm_req_stage #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [N*N-1:0]  occ,
    input  logic [N-1:0]    adv,
    output logic [N-1:0]    req_vld,
    output logic [N*PW-1:0] req_idx
);
    logic [PW-1:0] ptr  [N];
    logic [N-1:0]  pick_hit;
    logic [PW-1:0] pick_idx [N];

    for (genvar i = 0; i < N; i++) begin : g_in
        drrm_rr_pick #(.N(N), .PW(PW)) u_pick (
            .req (occ[i*N +: N]),
            .ptr (ptr[i]),
            .hit (pick_hit[i]),
            .idx (pick_idx[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr[i]              <= '0;
                req_vld[i]          <= 1'b0;
                req_idx[i*PW +: PW] <= '0;
            end else begin
                if (load) begin
                    req_vld[i]          <= pick_hit[i];
                    req_idx[i*PW +: PW] <= pick_idx[i];
                end
                if (adv[i]) begin
                    ptr[i] <= (req_idx[i*PW +: PW] == PW'(N-1)) ? '0
                            : req_idx[i*PW +: PW] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/drrm_grant_stage.sv
module drrm_grant_stage #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [N-1:0]    req_vld,
    input  logic [N*PW-1:0] req_idx,
    output logic [N*N-1:0]  gnt
);
    logic [PW-1:0] ptr  [N];
    logic [N-1:0]  col_req [N];
    logic [N-1:0]  win_hit;
    logic [PW-1:0] win_idx [N];

    for (genvar j = 0; j < N; j++) begin : g_out
        for (genvar i = 0; i < N; i++) begin : g_col
            assign col_req[j][i] = req_vld[i] && (req_idx[i*PW +: PW] == PW'(j));
        end

        drrm_rr_pick #(.N(N), .PW(PW)) u_pick (
            .req (col_req[j]),
            .ptr (ptr[j]),
            .hit (win_hit[j]),
            .idx (win_idx[j])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr[j] <= '0;
            end else if (commit && win_hit[j]) begin
                ptr[j] <= (win_idx[j] == PW'(N-1)) ? '0 : win_idx[j] + 1'b1;
            end
        end
    end

    always_comb begin
        gnt = '0;
        for (int j = 0; j < N; j++) begin
            if (win_hit[j]) gnt[int'(win_idx[j])*N + j] = 1'b1;
        end
    end
endmodule

// File: rtl/drrm_sched.sv
module drrm_sched
    import drrm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_i,
    input  logic [N*N-1:0] occ_i,
    output logic [N*N-1:0] grant_o,
    output logic           match_valid_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    drrm_state_e    state, state_nx;
    logic           load, commit;
    logic [N-1:0]   req_vld;
    logic [N*PW-1:0] req_idx;
    logic [N*N-1:0] gnt;
    logic [N-1:0]   row_gnt;

    assign load   = (state == ST_IDLE) && slot_i;
    assign commit = (state == ST_RESOLVE);

    for (genvar i = 0; i < N; i++) begin : g_row
        assign row_gnt[i] = commit && (|gnt[i*N +: N]);
    end

    drrm_req_stage #(.N(N), .PW(PW)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .occ     (occ_i),
        .adv     (row_gnt),
        .req_vld (req_vld),
        .req_idx (req_idx)
    );

    drrm_grant_stage #(.N(N), .PW(PW)) u_gnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .req_vld (req_vld),
        .req_idx (req_idx),
        .gnt     (gnt)
    );

    // Next-state logic: launch / publish
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (slot_i) state_nx = ST_RESOLVE;
            ST_RESOLVE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o       <= '0;
            match_valid_o <= 1'b0;
        end else begin
            match_valid_o <= commit;
            if (commit) grant_o <= gnt;
        end
    end
endmodule

// File: rtl/drrm_sched_chk.sv
module drrm_sched_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           slot_i,
    input logic [N*N-1:0] occ_i,
    input logic [N*N-1:0] grant_o,
    input logic           match_valid_o
);
    logic [N-1:0] col [N];

    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col[j][i] = grant_o[i*N + j];
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r5_row_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_o[k*N +: N]));
        a_r5_col_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[k]));
    end

    a_r5_grant_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid_o |-> ((grant_o & ~$past(occ_i, 2)) == '0));

    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid_o |=> !match_valid_o);

    a_r2_valid_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid_o |-> $past(slot_i, 2));

    a_r10_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid_o |-> $stable(grant_o));
endmodule

bind drrm_sched drrm_sched_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_i        (slot_i),
    .occ_i         (occ_i),
    .grant_o       (grant_o),
    .match_valid_o (match_valid_o)
);

// File: tb/drrm_sched_tb.sv
module drrm_sched_tb;
    localparam int N      = 4;
    localparam int CLK_NS = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           slot_i = 1'b0;
    logic [N*N-1:0] occ_i = '0;
    logic [N*N-1:0] grant_o;
    logic           match_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;
    int ip [N];
    int op [N];
    logic [N*N-1:0] exp_q [$];
    logic [N*N-1:0] last_exp = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_NS/2) clk = ~clk;

    drrm_sched #(.N(N)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_i        (slot_i),
        .occ_i         (occ_i),
        .grant_o       (grant_o),
        .match_valid_o (match_valid_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference model built from R3, R4, R6, R7
    task automatic model(input logic [N*N-1:0] occ, output logic [N*N-1:0] g);
        int sel [N];
        bit has [N];
        g = '0;
        for (int i = 0; i < N; i++) begin
            has[i] = 0;
            sel[i] = 0;
            for (int k = 0; k < N; k++) begin
                automatic int j = (ip[i] + k) % N;
                if (!has[i] && occ[i*N + j]) begin
                    has[i] = 1;
                    sel[i] = j;
                end
            end
        end
        for (int j = 0; j < N; j++) begin
            automatic bit got = 0;
            for (int k = 0; k < N; k++) begin
                automatic int i = (op[j] + k) % N;
                if (!got && has[i] && sel[i] == j) begin
                    got = 1;
                    g[i*N + j] = 1'b1;
                    op[j] = (i + 1) % N;
                    ip[i] = (j + 1) % N;
                end
            end
        end
    endtask

    // Driver: hold2 keeps the strobe up into RESOLVE (R8);
    // flip changes occupancy after launch (R9)
    task automatic run_slot(input logic [N*N-1:0] occ, input bit hold2, input bit flip);
        logic [N*N-1:0] g;
        int p0;
        @(negedge clk);
        occ_i  = occ;
        slot_i = 1'b1;
        model(occ, g);
        exp_q.push_back(g);
        p0 = pulses;
        @(negedge clk);
        check(match_valid_o == 1'b0, "R2 early valid", 64'(match_valid_o), 64'd0);
        slot_i = hold2;
        if (flip) occ_i = ~occ;
        @(negedge clk);
        slot_i = 1'b0;
        repeat (3) @(negedge clk);
        check(pulses - p0 == 1, "R8 one pulse per launch", 64'(pulses - p0), 64'd1);
    endtask

    // Monitor: scoreboard compare on each result
    always @(negedge clk) begin
        if (rst_n && match_valid_o) begin
            pulses++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", 64'(grant_o), 64'd0);
            end else begin
                last_exp = exp_q.pop_front();
                check(grant_o == last_exp, "R3 R4 R6 R7 matching",
                      64'(grant_o), 64'(last_exp));
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            ip[i] = 0;
            op[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(match_valid_o == 1'b0, "R1 valid after reset", 64'(match_valid_o), 64'd0);
        check(grant_o == '0, "R1 grant after reset", 64'(grant_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 pointers at 0: full load first grants input0->output0
        run_slot('1, 0, 0);
        check(grant_o == 16'h0001, "R1 zero pointers", 64'(grant_o), 64'h1);
        // R6 R7 desynchronisation under full load
        for (int s = 0; s < 5; s++) run_slot('1, 0, 0);
        // R10 empty occupancy gives valid with zero grant
        run_slot('0, 0, 0);
        check(grant_o == '0, "R10 empty grant", 64'(grant_o), 64'd0);
        // R3 single cell input2->output3
        run_slot(16'h1 << (2*N + 3), 0, 0);
        check(grant_o == (16'h1 << (2*N + 3)), "R3 single cell",
              64'(grant_o), 64'(16'h1 << (2*N + 3)));
        // R8 strobe held into RESOLVE
        run_slot('1, 1, 0);
        run_slot(16'h8421, 0, 0);
        // R9 occupancy flipped after launch
        run_slot(16'h00F3, 0, 1);
        run_slot(16'h5A5A, 0, 1);
        // Mixed patterns
        for (int s = 0; s < 40; s++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            run_slot(lfsr[N*N-1:0], s[2], s[3]);
        end
        // R10 grant holds with no strobe
        repeat (6) @(negedge clk);
        check(grant_o == last_exp, "R10 hold", 64'(grant_o), 64'(last_exp));
        check(exp_q.size() == 0, "R2 missing result", 64'(exp_q.size()), 64'd0);
        done = 1;
        finish_run();
    end
endmodule